// File: doc/BRIEF.md
# Byte-Lane Packing Transfer FIFOs

This block sits between a register bus and the byte-serial data port of a memory card. It keeps a 32-byte receive queue and a double-buffered transmit store of two 32-byte halves. Bus reads and writes of 1, 2 or 4 bytes unpack or pack byte lanes. The oldest byte of any access always sits in the most significant lane that the access width covers.

A command sequencer starts a transfer by pulsing `xfer_load` with a byte count and a direction. The block then either accepts card bytes into the receive queue or offers queued bytes to the card. It counts the bytes that remain. When the count reaches zero it returns to idle and raises the done flags. Interrupt routing lives elsewhere, so the block only exports request and done levels.

The controller has three states. `XF_IDLE` moves nothing. `XF_RECV` accepts card bytes. `XF_SEND` offers bytes to the card. There are four transitions:
- `xfer_load` with a non-zero count and `xfer_write`=0 goes to `XF_RECV`.
- `xfer_load` with a non-zero count and `xfer_write`=1 goes to `XF_SEND`.
- `xfer_load` with a zero count goes to `XF_IDLE`.
- Moving the last remaining byte goes from `XF_RECV` or `XF_SEND` back to `XF_IDLE`.

Top module: `lane_pack_fifo`

## Requirements
- R1: After reset, `card_rx_ready`, `card_tx_valid`, `rx_req`, `tx_req`, `data_done` and `prog_done` are 0, `bus_rdata` is 0, and both queues are empty.
- R2: On `xfer_load`, both queues empty and all request and done flags clear. A non-zero count enters `XF_RECV` (when `xfer_write`=0) or `XF_SEND` (when `xfer_write`=1). A zero count stays idle and sets `data_done` at once, and also `prog_done` when `xfer_write`=1.
- R3: In `XF_RECV`, `card_rx_ready` is 1 while fewer than 32 bytes are held and is 0 at 32. Each accepted byte decrements the remaining count and sets `rx_req`.
- R4: `bus_width` codes map to a width N. A read of width N pops min(N, held) bytes. The first popped byte goes to lane N-1 (bits 8N-1:8N-8), each later byte one lane lower. Lanes with no byte and lanes at or above N read 0. `bus_rdata` changes on the clock edge that samples `bus_rd` and holds otherwise.
- R5: A read clears `rx_req`, except when a card byte is accepted in the same cycle.
- R6: A write of width N queues min(N, 32-held) bytes, taking lane N-1 first. Bytes beyond 32 are dropped. Any write clears `tx_req`.
- R7: In `XF_SEND`, `card_tx_valid` is 1 while the queue holds a byte, and `card_tx_data` is the oldest byte. Each accepted byte decrements the remaining count.
- R8: One cycle after a cycle that is in `XF_SEND` with an empty queue and no bus write, `tx_req` is 1.
- R9: A `half_swap` pulse moves the transmit store to its other half and empties the queue. Bytes queued before the swap are never offered, and `card_tx_valid` is 0 in the swap cycle.
- R10: Moving the last remaining byte returns to `XF_IDLE` and sets `data_done`. It also sets `prog_done` only in the send direction. Both flags hold until the next `xfer_load`.
- R11: `bus_width` code 00 selects 1 byte, 01 selects 2 bytes, and 10 or 11 select 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_load | input | 1 | Start a transfer with the given count and direction |
| xfer_bytes | input | 28 | Byte count of the transfer |
| xfer_write | input | 1 | 1 = send to card, 0 = receive from card |
| bus_rd | input | 1 | Receive-queue read strobe |
| bus_wr | input | 1 | Transmit-queue write strobe |
| bus_width | input | 2 | Access width code for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| half_swap | input | 1 | Partial-buffer command: switch transmit half |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Block accepts the card byte |
| card_tx_valid | output | 1 | Byte offered to card |
| card_tx_data | output | 8 | Offered byte |
| card_tx_ready | input | 1 | Card accepts the offered byte |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| data_done | output | 1 | Transfer completed |
| prog_done | output | 1 | Send-direction transfer completed |

## Verification
`card_rx_ready` and `card_tx_valid`/`card_tx_data` are combinational. The bench samples them in the same cycle, a little after it drives the inputs and well before the next edge. `bus_rdata`, `rx_req`, the done flags and a state change caused by a load or a final byte are due one edge after the stimulus, so the bench samples them just after that edge. `tx_req` is due one edge after the first cycle spent in `XF_SEND` with an empty queue, which is two edges after a load; the bench waits one idle cycle before checking it. A random receive phase with a bench-side byte queue checks every ready level and every read word at these points.

// File: rtl/blf_pkg.sv
package blf_pkg;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_RECV = 2'd1,
        XF_SEND = 2'd2
    } xfer_state_t;

    // R11: width code to byte count
    function automatic logic [2:0] lane_count(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            2'b00:   n = 3'd1;
            2'b01:   n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/blf_rx_fifo.sv
module blf_rx_fifo
    import blf_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        fill_en,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        push_o,
    input  logic        rd,
    input  logic [1:0]  rd_code,
    output logic [31:0] rdata,
    output logic        req
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] head;
    logic [CW-1:0] cnt;
    logic [CW-1:0] n_ext;
    logic [CW-1:0] npop;
    logic [31:0]   packed_w;
    logic          push;

    assign n_ext    = CW'(lane_count(rd_code));
    assign in_ready = fill_en && !clr && (cnt < CW'(DEPTH));
    assign push     = in_valid && in_ready;
    assign push_o   = push;

    always_comb begin
        npop = '0;
        if (rd) npop = (cnt < n_ext) ? cnt : n_ext;
    end

    // R4: first popped byte to lane N-1, then downwards
    always_comb begin
        packed_w = '0;
        for (int j = 0; j < 4; j++) begin
            if (j < int'(n_ext)) begin
                if ((int'(n_ext) - 1 - j) < int'(npop))
                    packed_w[8*j +: 8] = mem[AW'(int'(head) + int'(n_ext) - 1 - j)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            head  <= '0;
            req   <= 1'b0;
            rdata <= '0;
        end else if (clr) begin
            cnt  <= '0;
            head <= '0;
            req  <= 1'b0;
        end else begin
            cnt  <= cnt + CW'(push) - npop;
            head <= head + AW'(npop);
            if (push)    req <= 1'b1;
            else if (rd) req <= 1'b0;
            if (rd)      rdata <= packed_w;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[AW'(head + cnt[AW-1:0])] <= in_data;
    end

    a_r3_full_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH)) |-> !in_ready);
    a_r3_push_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |=> req);
    a_r5_read_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !push) |=> !req);

endmodule

// File: rtl/blf_tx_fifo.sv
module blf_tx_fifo
    import blf_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        swap,
    input  logic        drain_en,
    input  logic        wr,
    input  logic [1:0]  wr_code,
    input  logic [31:0] wdata,
    output logic        out_valid,
    output logic [7:0]  out_data,
    input  logic        out_ready,
    output logic        pop_o,
    output logic        empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]    mem [2*DEPTH];
    logic          half;
    logic [AW-1:0] head;
    logic [CW-1:0] cnt;
    logic [CW-1:0] n_ext;
    logic [CW-1:0] room;
    logic [CW-1:0] npush;
    logic          pop;

    assign n_ext     = CW'(lane_count(wr_code));
    assign room      = CW'(DEPTH) - cnt;
    assign npush     = (wr && !clr && !swap) ? ((room < n_ext) ? room : n_ext) : '0;
    assign out_valid = drain_en && !clr && !swap && (cnt != '0);
    assign out_data  = mem[{half, head}];
    assign pop       = out_valid && out_ready;
    assign pop_o     = pop;
    assign empty     = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            head <= '0;
            half <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            head <= '0;
        end else if (swap) begin
            half <= ~half;
            cnt  <= '0;
        end else begin
            cnt  <= cnt + npush - CW'(pop);
            head <= head + AW'(pop);
        end
    end

    // R6: lane N-1 is queued first
    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (i < int'(npush))
                mem[{half, AW'(int'(head) + int'(cnt) + i)}] <=
                    wdata[8*(int'(n_ext) - 1 - i) +: 8];
        end
    end

    a_r9_swap_hides_old: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !clr) |=> !out_valid);
    a_r6_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH) && wr && !pop && !clr && !swap) |=> (cnt == CW'(DEPTH)));
    a_r7_valid_only_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        (swap || clr) |=> (cnt == '0));

endmodule

// File: rtl/blf_xfer_ctrl.sv
module blf_xfer_ctrl
    import blf_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_bytes,
    input  logic             load_write,
    input  logic             rx_moved,
    input  logic             tx_moved,
    input  logic             bus_wr,
    input  logic             tx_empty,
    output logic             fill_en,
    output logic             drain_en,
    output logic             tx_req,
    output logic             data_done,
    output logic             prog_done
);
    xfer_state_t      state_q, state_d;
    logic [CNT_W-1:0] rem_q, rem_d;
    logic             dir_q;
    logic             moved;
    logic             finish;

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        moved   = 1'b0;
        unique case (state_q)
            XF_IDLE: moved = 1'b0;
            XF_RECV: moved = rx_moved;
            XF_SEND: moved = tx_moved;
            default: moved = 1'b0;
        endcase
        finish = moved && (rem_q == CNT_W'(1)) && !load;
        if (moved) rem_d = rem_q - CNT_W'(1);
        if (finish) state_d = XF_IDLE;
        if (load) begin
            rem_d = load_bytes;
            if (load_bytes == '0)  state_d = XF_IDLE;
            else if (load_write)   state_d = XF_SEND;
            else                   state_d = XF_RECV;
        end
        fill_en  = (state_q == XF_RECV);
        drain_en = (state_q == XF_SEND);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_IDLE;
            rem_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            if (load) dir_q <= load_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_req    <= 1'b0;
            data_done <= 1'b0;
            prog_done <= 1'b0;
        end else if (load) begin
            tx_req    <= 1'b0;
            data_done <= (load_bytes == '0);
            prog_done <= (load_bytes == '0) && load_write;
        end else begin
            if (finish) begin
                data_done <= 1'b1;
                prog_done <= dir_q;
            end
            if (bus_wr)
                tx_req <= 1'b0;
            else if (state_q == XF_SEND && tx_empty)
                tx_req <= 1'b1;
        end
    end

    a_r10_active_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != XF_IDLE) |-> (rem_q != '0));
    a_r10_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |-> (state_q == XF_IDLE));
    a_r2_zero_load_done: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_bytes == '0) |=> (data_done && state_q == XF_IDLE));
    a_r8_write_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !load) |=> !tx_req);

endmodule

// File: rtl/lane_pack_fifo.sv
module lane_pack_fifo
    import blf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_load,
    input  logic [CNT_W-1:0] xfer_bytes,
    input  logic             xfer_write,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_width,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             half_swap,
    input  logic             card_rx_valid,
    input  logic [7:0]       card_rx_data,
    output logic             card_rx_ready,
    output logic             card_tx_valid,
    output logic [7:0]       card_tx_data,
    input  logic             card_tx_ready,
    output logic             rx_req,
    output logic             tx_req,
    output logic             data_done,
    output logic             prog_done
);
    logic fill_en, drain_en, rx_push, tx_pop, tx_empty;

    blf_xfer_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .load(xfer_load), .load_bytes(xfer_bytes), .load_write(xfer_write),
        .rx_moved(rx_push), .tx_moved(tx_pop),
        .bus_wr(bus_wr), .tx_empty(tx_empty),
        .fill_en(fill_en), .drain_en(drain_en),
        .tx_req(tx_req), .data_done(data_done), .prog_done(prog_done)
    );

    blf_rx_fifo #(.DEPTH(DEPTH)) rx_i (
        .clk(clk), .rst_n(rst_n), .clr(xfer_load), .fill_en(fill_en),
        .in_valid(card_rx_valid), .in_data(card_rx_data), .in_ready(card_rx_ready),
        .push_o(rx_push), .rd(bus_rd), .rd_code(bus_width),
        .rdata(bus_rdata), .req(rx_req)
    );

    blf_tx_fifo #(.DEPTH(DEPTH)) tx_i (
        .clk(clk), .rst_n(rst_n), .clr(xfer_load), .swap(half_swap),
        .drain_en(drain_en), .wr(bus_wr), .wr_code(bus_width), .wdata(bus_wdata),
        .out_valid(card_tx_valid), .out_data(card_tx_data), .out_ready(card_tx_ready),
        .pop_o(tx_pop), .empty(tx_empty)
    );

endmodule

// File: tb/lane_pack_fifo_tb.sv
module lane_pack_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_load = 1'b0;
    logic [27:0] xfer_bytes = '0;
    logic        xfer_write = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_width = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        half_swap = 1'b0;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_data = '0;
    logic        card_rx_ready, card_tx_valid;
    logic [7:0]  card_tx_data;
    logic        card_tx_ready = 1'b0;
    logic        rx_req, tx_req, data_done, prog_done;

    int checks = 0;
    int errors = 0;
    logic [7:0] rq[$];

    always #4 clk = ~clk;

    lane_pack_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_load(xfer_load), .xfer_bytes(xfer_bytes),
        .xfer_write(xfer_write), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_width(bus_width),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .half_swap(half_swap),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
        .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
        .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
        .rx_req(rx_req), .tx_req(tx_req), .data_done(data_done), .prog_done(prog_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    // expected read word from the bench queue (R4, R11 width codes)
    function automatic logic [31:0] model_pop(input logic [1:0] code);
        logic [31:0] r;
        int n;
        n = (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
        r = '0;
        for (int i = 0; i < n; i++)
            if (rq.size() > 0) r[8*(n-1-i) +: 8] = rq.pop_front();
        return r;
    endfunction

    task automatic do_load(input int bytes, input logic w);
        xfer_load = 1'b1; xfer_bytes = 28'(bytes); xfer_write = w;
        cyc();
        xfer_load = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] code, output logic [31:0] d);
        bus_rd = 1'b1; bus_width = code;
        cyc();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_write(input logic [1:0] code, input logic [31:0] v);
        bus_wr = 1'b1; bus_width = code; bus_wdata = v;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic expect_tx(input string tag, input logic [7:0] b);
        card_tx_ready = 1'b1;
        #1;
        chk({tag, " valid"}, 32'(card_tx_valid), 32'd1);
        chk({tag, " data"}, 32'(card_tx_data), 32'(b));
        cyc();
        card_tx_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, e;
        void'($urandom(32'h5EED_1234));
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1
        chk("R1 rx_ready", 32'(card_rx_ready), 0);
        chk("R1 tx_valid", 32'(card_tx_valid), 0);
        chk("R1 flags", {28'd0, rx_req, tx_req, data_done, prog_done}, 0);
        chk("R1 rdata", bus_rdata, 0);

        // R2 zero-length send load
        do_load(0, 1'b1);
        chk("R2 zero load done", {30'd0, data_done, prog_done}, 32'h3);

        // R3/R4/R5/R10 directed receive
        do_load(5, 1'b0);
        chk("R2 load clears done", 32'(data_done), 0);
        #1 chk("R3 ready in recv", 32'(card_rx_ready), 1);
        for (int i = 0; i < 5; i++) begin
            card_rx_valid = 1'b1; card_rx_data = 8'hA1 + 8'(i);
            cyc();
        end
        card_rx_valid = 1'b0;
        chk("R3 rx_req set", 32'(rx_req), 1);
        #1 chk("R10 rx idle ready", 32'(card_rx_ready), 0);
        chk("R10 rx done", {30'd0, data_done, prog_done}, 32'h2);
        do_read(2'b10, d);
        chk("R4 wide read order", d, 32'hA1A2A3A4);
        chk("R5 read clears rx_req", 32'(rx_req), 0);
        do_read(2'b01, d);
        chk("R4 partial half read", d, 32'h0000A500);
        do_read(2'b00, d);
        chk("R4 empty read zero", d, 0);

        // R3 full queue
        do_load(40, 1'b0);
        for (int i = 0; i < 32; i++) begin
            card_rx_valid = 1'b1; card_rx_data = 8'h40 + 8'(i);
            #1 chk("R3 ready below full", 32'(card_rx_ready), 1);
            cyc();
        end
        #1 chk("R3 ready low at full", 32'(card_rx_ready), 0);
        card_rx_valid = 1'b0;
        do_read(2'b11, d);
        chk("R11 code 11 four bytes", d, 32'h40414243);
        #1 chk("R3 ready after pop", 32'(card_rx_ready), 1);

        // random receive against bench queue
        rq.delete();
        do_load(200, 1'b0);
        begin
            int rem;
            rem = 200;
            for (int c = 0; c < 3000 && (rem > 0 || rq.size() > 0); c++) begin
                logic v, r, push, er;
                logic [1:0] code;
                logic [7:0] b;
                v = 1'($urandom % 2);
                r = ($urandom % 3) == 0;
                code = 2'($urandom % 4);
                b = 8'($urandom);
                card_rx_valid = v; card_rx_data = b; bus_rd = r; bus_width = code;
                #1;
                er = (rem > 0) && (rq.size() < 32);
                chk("R3 random ready", 32'(card_rx_ready), 32'(er));
                push = v && er;
                e = r ? model_pop(code) : 32'd0;
                if (push) begin rq.push_back(b); rem--; end
                cyc();
                if (r) chk("R4 random read", bus_rdata, e);
            end
            card_rx_valid = 1'b0; bus_rd = 1'b0;
            chk("R10 random recv done", {30'd0, data_done, prog_done}, 32'h2);
        end

        // transmit directed
        do_load(6, 1'b1);
        cyc();
        chk("R8 tx_req when empty", 32'(tx_req), 1);
        chk("R7 no valid when empty", 32'(card_tx_valid), 0);
        do_write(2'b10, 32'h11223344);
        chk("R6 write clears tx_req", 32'(tx_req), 0);
        do_write(2'b01, 32'h00005566);
        expect_tx("R7 b0", 8'h11);
        expect_tx("R7 b1", 8'h22);
        expect_tx("R7 b2", 8'h33);
        expect_tx("R7 b3", 8'h44);
        expect_tx("R11 half b4", 8'h55);
        expect_tx("R11 half b5", 8'h66);
        chk("R10 send done", {30'd0, data_done, prog_done}, 32'h3);
        #1 chk("R10 send idle valid", 32'(card_tx_valid), 0);

        // R6 overflow drop
        do_load(40, 1'b1);
        for (int i = 0; i < 8; i++)
            do_write(2'b10, {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
        do_write(2'b10, 32'hDEADBEEF);
        for (int i = 0; i < 32; i++) expect_tx("R6 full order", 8'(i));
        #1 chk("R6 excess dropped", 32'(card_tx_valid), 0);
        cyc();
        chk("R8 tx_req after drain", 32'(tx_req), 1);

        // R9 half swap
        do_load(10, 1'b1);
        do_write(2'b10, 32'hAABBCCDD);
        half_swap = 1'b1;
        #1 chk("R9 valid low in swap", 32'(card_tx_valid), 0);
        cyc();
        half_swap = 1'b0;
        #1 chk("R9 queue empty after swap", 32'(card_tx_valid), 0);
        do_write(2'b00, 32'h000000EE);
        do_write(2'b11, 32'h01020304);
        expect_tx("R9 new half first", 8'hEE);
        expect_tx("R11 code 11 b0", 8'h01);
        expect_tx("R11 code 11 b1", 8'h02);
        expect_tx("R11 code 11 b2", 8'h03);
        expect_tx("R11 code 11 b3", 8'h04);
        #1 chk("R9 old bytes never sent", 32'(card_tx_valid), 0);
        chk("R10 not done early", 32'(data_done), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule